// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps wall-clock time as packed BCD: seconds, minutes, hours, day of month, weekday, month and a two-digit year. A sub-second prescaler counts pulses on a tick-enable input and advances the seconds once every `SUBTICKS` pulses. Carries ripple upward through minutes, hours, the day and weekday pair, month and year. Day rollover follows the length of each month. February gains a 29th day when the year is divisible by four. A year wrap from 99 to 00 flips a century bit.

Software reaches the time through a byte-wide register port. Reads are combinational. Writes take effect on the next clock edge. A control register holds a stop bit that freezes the counter so a new time can be loaded safely. The top bit of the seconds register is a validity flag. It is set at power-on and means the stored time cannot be trusted until the seconds have been written.

For a downstream alarm comparator, the block exports a one-cycle minute pulse and the live minute, hour, day and weekday fields.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the registers read as follows: seconds (address 0x02) 0x80, minutes (0x03) 0x00, hours (0x04) 0x00, day (0x05) 0x01, weekday (0x06) 0x00, month (0x07) 0x01, year (0x08) 0x00 and control (0x00) 0x00.
- R2: The seconds register advances by one BCD count on the clock edge that samples the `SUBTICKS`-th tick-enable pulse since the last restart of the prescaler.
- R3: Seconds and minutes run in BCD from 00 to 59, then return to 00 and carry. `minute_tick` is high for exactly the one cycle in which seconds first read 00 after a rollover.
- R4: Hours run from 00 to 23. Their rollover increments both the day and the weekday, and the weekday wraps from 6 to 0.
- R5: The day wraps to 01 after 30 in months 0x04, 0x06, 0x09 and 0x11, and after 31 in the other months. In month 0x02 it wraps after 29 when the year is divisible by four (00 included) and after 28 otherwise.
- R6: The month wraps from 0x12 to 0x01 and increments the year. A year wrap from 0x99 to 0x00 toggles the century bit, which is bit 7 of the month register.
- R7: Bit 5 of the control register is the stop bit. While it is 1, no time register advances and the prescaler is held at zero.
- R8: Writes keep only the significant bits: seconds 7, minutes 7, hours 6, day 6, weekday 3, month 5 plus the century bit 7, year 8, and control bit 5 only. Other bits, and addresses with no register, read 0.
- R9: Bit 7 of seconds is the voltage-low flag. Reset sets it. Only a write to address 0x02 clears it, and the counter advancing does not clear it.
- R10: A write to any address from 0x02 to 0x08 restarts the prescaler, so a full `SUBTICKS` pulses must follow before the next advance. A write in the same cycle as an advance wins, and that advance is dropped.
- R11: `out_min`, `out_hour`, `out_day` and `out_wday` equal the contents of the matching registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Sub-second pulse, one clock wide |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| minute_tick | output | 1 | One-cycle pulse on each seconds rollover |
| out_min | output | 7 | Current minutes, BCD |
| out_hour | output | 6 | Current hours, BCD |
| out_day | output | 6 | Current day of month, BCD |
| out_wday | output | 3 | Current weekday, 0 is Sunday |

## Verification
Each time register changes on the same clock edge that samples the final tick-enable pulse. The whole carry chain is combinational, so a seconds rollover shows in the year field on that edge too. `minute_tick` rises on that edge and falls one edge later. The bench drives each pulse at a falling edge and returns at the next falling edge, so every result is already in place when the bench looks at it. The bench reads `minute_tick` straight after the pulse, before any further edge. Register reads are combinational and are sampled 1 ns after the address settles.

// File: rtl/cal_pkg.sv
package cal_pkg;
   localparam int ADR_CTRL = 0;
   localparam int ADR_SEC  = 2;
   localparam int ADR_MIN  = 3;
   localparam int ADR_HOUR = 4;
   localparam int ADR_DAY  = 5;
   localparam int ADR_WDAY = 6;
   localparam int ADR_MON  = 7;
   localparam int ADR_YEAR = 8;
   localparam int STOP_BIT = 5;

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   function automatic logic year_is_leap(input logic [7:0] y);
      logic [7:0] b;
      b = ({4'd0, y[7:4]} * 8'd10) + {4'd0, y[3:0]};
      return (b[1:0] == 2'b00);
   endfunction

   function automatic logic [7:0] last_day(input logic [4:0] mon, input logic [7:0] yr);
      case (mon)
         5'h02:                      return year_is_leap(yr) ? 8'h29 : 8'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction
endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
   parameter int SUBTICKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic restart,
   input  logic hold,
   output logic sec_adv
);
   if (SUBTICKS < 1) begin : g_bad_subticks
      $error("cal_prescaler: SUBTICKS must be at least 1");
   end

   if (SUBTICKS == 1) begin : g_direct
      assign sec_adv = tick_en & ~hold & ~restart;
   end else begin : g_count
      localparam int CW = $clog2(SUBTICKS);
      localparam logic [CW-1:0] LAST = CW'(SUBTICKS - 1);
      logic [CW-1:0] cnt_q;

      assign sec_adv = tick_en & ~hold & ~restart & (cnt_q == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                cnt_q <= '0;
         else if (hold || restart)  cnt_q <= '0;
         else if (tick_en)          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/cal_bcd_wrap.sv
module cal_bcd_wrap #(
   parameter int         W       = 8,
   parameter logic [7:0] MIN_VAL = 8'h00
) (
   input  logic [W-1:0] cur,
   input  logic [7:0]   limit,
   input  logic         step,
   output logic [W-1:0] nxt,
   output logic         carry
);
   import cal_pkg::*;

   if (W < 3 || W > 8) begin : g_bad_width
      $error("cal_bcd_wrap: W must lie in 3..8");
   end

   logic [7:0] cur8;
   logic [7:0] inc8;
   logic       wrap;

   always_comb begin
      cur8  = 8'(cur);
      inc8  = bcd_inc(cur8);
      wrap  = (cur8 >= limit);
      carry = step & wrap;
      if (!step)     nxt = cur;
      else if (wrap) nxt = MIN_VAL[W-1:0];
      else           nxt = inc8[W-1:0];
   end
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock #(
   parameter int SUBTICKS = 4,
   parameter int ADDR_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              minute_tick,
   output logic [6:0]        out_min,
   output logic [5:0]        out_hour,
   output logic [5:0]        out_day,
   output logic [2:0]        out_wday
);
   import cal_pkg::*;

   if (ADDR_W < 4) begin : g_bad_addr
      $error("bcd_calendar_clock: ADDR_W must be at least 4");
   end

   logic [6:0] sec_q, min_q;
   logic [5:0] hour_q, day_q;
   logic [2:0] wday_q;
   logic [4:0] mon_q;
   logic [7:0] year_q;
   logic       vl_q, cent_q, stop_q, mtick_q;

   logic [6:0] sec_n, min_n;
   logic [5:0] hour_n, day_n;
   logic [2:0] wday_n;
   logic [4:0] mon_n;
   logic [7:0] year_n;
   logic       c_sec, c_min, c_hour, c_day, c_wday, c_mon, c_year;
   logic       time_wr, sec_adv;

   assign time_wr = reg_wr && (reg_addr >= ADDR_W'(ADR_SEC)) && (reg_addr <= ADDR_W'(ADR_YEAR));

   cal_prescaler #(.SUBTICKS(SUBTICKS)) u_presc (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .restart(time_wr), .hold(stop_q), .sec_adv(sec_adv)
   );

   cal_bcd_wrap #(.W(7), .MIN_VAL(8'h00)) u_sec (
      .cur(sec_q), .limit(8'h59), .step(sec_adv), .nxt(sec_n), .carry(c_sec));
   cal_bcd_wrap #(.W(7), .MIN_VAL(8'h00)) u_min (
      .cur(min_q), .limit(8'h59), .step(c_sec), .nxt(min_n), .carry(c_min));
   cal_bcd_wrap #(.W(6), .MIN_VAL(8'h00)) u_hour (
      .cur(hour_q), .limit(8'h23), .step(c_min), .nxt(hour_n), .carry(c_hour));
   cal_bcd_wrap #(.W(6), .MIN_VAL(8'h01)) u_day (
      .cur(day_q), .limit(last_day(mon_q, year_q)), .step(c_hour), .nxt(day_n), .carry(c_day));
   cal_bcd_wrap #(.W(3), .MIN_VAL(8'h00)) u_wday (
      .cur(wday_q), .limit(8'h06), .step(c_hour), .nxt(wday_n), .carry(c_wday));
   cal_bcd_wrap #(.W(5), .MIN_VAL(8'h01)) u_mon (
      .cur(mon_q), .limit(8'h12), .step(c_day), .nxt(mon_n), .carry(c_mon));
   cal_bcd_wrap #(.W(8), .MIN_VAL(8'h00)) u_year (
      .cur(year_q), .limit(8'h99), .step(c_mon), .nxt(year_n), .carry(c_year));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q   <= '0;
         min_q   <= '0;
         hour_q  <= '0;
         day_q   <= 6'h01;
         wday_q  <= '0;
         mon_q   <= 5'h01;
         year_q  <= '0;
         vl_q    <= 1'b1;
         cent_q  <= 1'b0;
         stop_q  <= 1'b0;
         mtick_q <= 1'b0;
      end else begin
         sec_q   <= sec_n;
         min_q   <= min_n;
         hour_q  <= hour_n;
         day_q   <= day_n;
         wday_q  <= wday_n;
         mon_q   <= mon_n;
         year_q  <= year_n;
         mtick_q <= c_sec;
         if (c_year) cent_q <= ~cent_q;
         if (reg_wr) begin
            case (int'(reg_addr))
               ADR_CTRL: stop_q <= reg_wdata[STOP_BIT];
               ADR_SEC: begin
                  sec_q <= reg_wdata[6:0];
                  vl_q  <= 1'b0;
               end
               ADR_MIN:  min_q  <= reg_wdata[6:0];
               ADR_HOUR: hour_q <= reg_wdata[5:0];
               ADR_DAY:  day_q  <= reg_wdata[5:0];
               ADR_WDAY: wday_q <= reg_wdata[2:0];
               ADR_MON: begin
                  mon_q  <= reg_wdata[4:0];
                  cent_q <= reg_wdata[7];
               end
               ADR_YEAR: year_q <= reg_wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (int'(reg_addr))
         ADR_CTRL: reg_rdata = {2'b00, stop_q, 5'b00000};
         ADR_SEC:  reg_rdata = {vl_q, sec_q};
         ADR_MIN:  reg_rdata = {1'b0, min_q};
         ADR_HOUR: reg_rdata = {2'b00, hour_q};
         ADR_DAY:  reg_rdata = {2'b00, day_q};
         ADR_WDAY: reg_rdata = {5'b00000, wday_q};
         ADR_MON:  reg_rdata = {cent_q, 2'b00, mon_q};
         ADR_YEAR: reg_rdata = year_q;
         default:  reg_rdata = 8'h00;
      endcase
   end

   assign minute_tick = mtick_q;
   assign out_min     = min_q;
   assign out_hour    = hour_q;
   assign out_day     = day_q;
   assign out_wday    = wday_q;
endmodule

// File: rtl/cal_clock_checker.sv
module cal_clock_checker #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              stop,
   input logic              adv,
   input logic [6:0]        sec,
   input logic              vl,
   input logic [7:0]        year,
   input logic              cent,
   input logic              mtick
);
   logic twr;
   assign twr = reg_wr && (reg_addr >= ADDR_W'(2)) && (reg_addr <= ADDR_W'(8));

   assert_stop_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !reg_wr) |=> $stable(sec));

   assert_tick_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mtick |-> (sec == 7'h00));

   assert_tick_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mtick |=> !mtick);

   assert_vl_only_by_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vl) |-> $past(reg_wr && reg_addr == ADDR_W'(2)));

   assert_century_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(cent) && !$past(reg_wr)) |-> (year == 8'h00));

   assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      adv |-> (!twr && !stop));
endmodule

bind bcd_calendar_clock cal_clock_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .stop(stop_q), .adv(sec_adv), .sec(sec_q), .vl(vl_q),
   .year(year_q), .cent(cent_q), .mtick(mtick_q)
);

// File: tb/bcd_calendar_clock_tb.sv
module bcd_calendar_clock_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic [3:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       minute_tick;
   logic [6:0] out_min;
   logic [5:0] out_hour, out_day;
   logic [2:0] out_wday;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   bcd_calendar_clock #(.SUBTICKS(4), .ADDR_W(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .minute_tick(minute_tick), .out_min(out_min), .out_hour(out_hour),
      .out_day(out_day), .out_wday(out_wday)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
      logic [7:0] d;
      rd(a, d);
      chk(req, d, exp);
   endtask

   task automatic tick(input int n);
      repeat (n) begin
         @(negedge clk) tick_en = 1'b1;
         @(negedge clk) tick_en = 1'b0;
      end
   endtask

   task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                           input logic [7:0] d, input logic [7:0] w, input logic [7:0] mo,
                           input logic [7:0] y);
      wr(4'h0, 8'h20);
      wr(4'h2, s); wr(4'h3, m); wr(4'h4, h); wr(4'h5, d);
      wr(4'h6, w); wr(4'h7, mo); wr(4'h8, y);
      wr(4'h0, 8'h00);
   endtask

   task automatic t_reset;
      rd_chk("R1 sec", 4'h2, 8'h80);
      rd_chk("R1 min", 4'h3, 8'h00);
      rd_chk("R1 hour", 4'h4, 8'h00);
      rd_chk("R1 day", 4'h5, 8'h01);
      rd_chk("R1 wday", 4'h6, 8'h00);
      rd_chk("R1 month", 4'h7, 8'h01);
      rd_chk("R1 year", 4'h8, 8'h00);
      rd_chk("R1 ctrl", 4'h0, 8'h00);
      chk("R11 out_day", {2'b0, out_day}, 8'h01);
   endtask

   task automatic t_seconds;
      tick(3);
      rd_chk("R2 before last pulse", 4'h2, 8'h80);
      tick(1);
      rd_chk("R9 flag kept while counting", 4'h2, 8'h81);
      wr(4'h3, 8'h00);
      rd_chk("R9 minute write keeps flag", 4'h2, 8'h81);
      wr(4'h2, 8'h58);
      rd_chk("R9 seconds write clears flag", 4'h2, 8'h58);
      tick(4);
      rd_chk("R2 one step", 4'h2, 8'h59);
      tick(4);
      chk("R3 minute_tick high", {7'b0, minute_tick}, 8'h01);
      rd_chk("R3 seconds wrap", 4'h2, 8'h00);
      chk("R3 minute_tick one cycle", {7'b0, minute_tick}, 8'h00);
      rd_chk("R3 minute carry", 4'h3, 8'h01);
      chk("R11 out_min", {1'b0, out_min}, 8'h01);
   endtask

   task automatic t_hours_and_stop;
      set_time(8'h59, 8'h59, 8'h23, 8'h15, 8'h06, 8'h03, 8'h21);
      tick(4);
      rd_chk("R3 minute wrap", 4'h3, 8'h00);
      rd_chk("R4 hour wrap", 4'h4, 8'h00);
      rd_chk("R4 day carry", 4'h5, 8'h16);
      rd_chk("R4 weekday wrap", 4'h6, 8'h00);
      chk("R11 out_hour/out_wday", {out_wday, 2'b0, out_hour[2:0]}, 8'h00);
      wr(4'h0, 8'h20);
      tick(8);
      rd_chk("R7 frozen while stopped", 4'h2, 8'h00);
      wr(4'h0, 8'h00);
      tick(3);
      rd_chk("R7 prescaler held at zero", 4'h2, 8'h00);
      tick(1);
      rd_chk("R7 resumes", 4'h2, 8'h01);
   endtask

   task automatic roll_day(input string req, input logic [7:0] d, input logic [7:0] mo,
                           input logic [7:0] y, input logic [7:0] ed, input logic [7:0] emo);
      set_time(8'h59, 8'h59, 8'h23, d, 8'h03, mo, y);
      tick(4);
      rd_chk(req, 4'h5, ed);
      rd_chk(req, 4'h7, emo);
   endtask

   task automatic t_month_lengths;
      roll_day("R5 april 30", 8'h30, 8'h04, 8'h23, 8'h01, 8'h05);
      roll_day("R5 june 29", 8'h29, 8'h06, 8'h23, 8'h30, 8'h06);
      roll_day("R5 january 31", 8'h31, 8'h01, 8'h23, 8'h01, 8'h02);
      roll_day("R5 feb 28 plain year", 8'h28, 8'h02, 8'h23, 8'h01, 8'h03);
      roll_day("R5 feb 28 leap year", 8'h28, 8'h02, 8'h24, 8'h29, 8'h02);
      roll_day("R5 feb 29 year 00", 8'h29, 8'h02, 8'h00, 8'h01, 8'h03);
   endtask

   task automatic t_years;
      set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h02, 8'h12, 8'h45);
      tick(4);
      rd_chk("R6 december wrap", 4'h7, 8'h01);
      rd_chk("R6 year carry", 4'h8, 8'h46);
      set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h02, 8'h12, 8'h99);
      tick(4);
      rd_chk("R6 century set", 4'h7, 8'h81);
      rd_chk("R6 year 00", 4'h8, 8'h00);
      set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h02, 8'h92, 8'h99);
      tick(4);
      rd_chk("R6 century cleared", 4'h7, 8'h01);
   endtask

   task automatic t_masks;
      wr(4'h0, 8'hFF);
      rd_chk("R8 control", 4'h0, 8'h20);
      wr(4'h2, 8'hFF); rd_chk("R8 seconds", 4'h2, 8'h7F);
      wr(4'h3, 8'hFF); rd_chk("R8 minutes", 4'h3, 8'h7F);
      wr(4'h4, 8'hFF); rd_chk("R8 hours", 4'h4, 8'h3F);
      wr(4'h5, 8'hFF); rd_chk("R8 day", 4'h5, 8'h3F);
      wr(4'h6, 8'hFF); rd_chk("R8 weekday", 4'h6, 8'h07);
      wr(4'h7, 8'hFF); rd_chk("R8 month", 4'h7, 8'h9F);
      wr(4'h8, 8'hFF); rd_chk("R8 year", 4'h8, 8'hFF);
      wr(4'h9, 8'hFF); rd_chk("R8 empty address", 4'h9, 8'h00);
      rd_chk("R8 address 1", 4'h1, 8'h00);
      wr(4'h0, 8'h00);
   endtask

   task automatic t_restart;
      set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00);
      tick(2);
      wr(4'h3, 8'h05);
      tick(3);
      rd_chk("R10 restart after write", 4'h2, 8'h10);
      tick(1);
      rd_chk("R10 full period then step", 4'h2, 8'h11);
      tick(3);
      @(negedge clk);
      tick_en = 1'b1; reg_addr = 4'h2; reg_wdata = 8'h30; reg_wr = 1'b1;
      @(negedge clk);
      tick_en = 1'b0; reg_wr = 1'b0;
      rd_chk("R10 write wins", 4'h2, 8'h30);
      tick(3);
      rd_chk("R10 no early step", 4'h2, 8'h30);
      tick(1);
      rd_chk("R10 step after write", 4'h2, 8'h31);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_seconds();
      t_hours_and_stop();
      t_month_lengths();
      t_years();
      t_masks();
      t_restart();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule